// File: doc/BRIEF.md
# PCI Configuration Access Port

This block converts two-step CPU I/O accesses into PCI configuration transactions. Software first writes a 32-bit target descriptor to an address port. It then reads or writes a four-byte data window. While the descriptor's enable bit is set, each data-window access becomes one configuration request. The request carries the bus, device, function, dword index, byte lanes and (for writes) data.

Requests aimed at the host bridge itself (bus 0, device 0, function 0) are served by a small internal header register file. Other functions of device 0 on bus 0 are treated as absent. Every other target goes out on a request/acknowledge configuration interface, marked type 0 for bus 0 and type 1 for any other bus. A request that is not acknowledged within a fixed number of cycles is closed: reads return all ones and writes are discarded. Every I/O access the block does not claim is passed unchanged to a forwarding interface.

The CPU side uses a held request with a one-cycle acknowledge. The master keeps `io_req` and its qualifiers stable until it sees `io_ack`. Read data is valid while `io_ack` is high. I/O addresses are given as dword port numbers, with byte lanes on `io_be`. The address port is dword 0x33E (I/O 0CF8h). The data window is dword 0x33F (I/O 0CFCh–0CFFh).

Top module: `cfg_access_port`

## Requirements
- R1: After a full write of 0x80000004 to the address port, a data-window access reaches dword 1 of the host bridge header (command in bits 15:0, status in bits 31:16). Every CPU access completes with `io_ack` high for exactly one cycle.
- R2: The descriptor is loaded only by a write to the address port with `io_be` = 4'b1111. Narrower accesses to that port leave it unchanged and are forwarded as ordinary I/O.
- R3: A full read of the address port returns the descriptor. Bit 31 is enable, 23:16 bus, 15:11 device, 10:8 function and 7:2 dword index. Bits 30:24 and 1:0 always read zero, whatever was written.
- R4: While the enable bit is 0, data-window accesses are forwarded as ordinary I/O and raise no configuration request.
- R5: The byte lanes of a data-window access select the configuration bytes. Lane i covers bits 8i+7:8i. For the host header, a write changes only the selected command bytes. Externally, `cfg_be` equals the access's `io_be`.
- R6: The host header reads as follows. Dword 0 is {DEVICE_ID, VENDOR_ID}. Dword 1 has status 0 in bits 31:16 and the command in bits 15:0; only bits set in CMD_WMASK are writable, and the command resets to 0. Dword 2 is CLASS_REV. All other dwords read 0 and ignore writes.
- R7: Accesses to bus 0, device 0 with function ≠ 0 raise no external request. Reads return 0xFFFFFFFF and writes have no effect.
- R8: Any other enabled target raises `cfg_req` with the latched bus, device, function and dword index. `cfg_type1` is 0 for bus 0 and 1 otherwise. The read data returned is `cfg_rdata`.
- R9: If `cfg_ack` does not arrive, `cfg_req` drops after exactly TIMEOUT_CYC cycles. A read then returns 0xFFFFFFFF and a write completes with no effect.
- R10: Accesses to any other I/O port are forwarded with the same port, byte lanes, direction and data, and `fwd_rdata` is returned. The configuration and forwarding requests are never active together.
- R11: After reset the descriptor reads 0, the enable bit is clear and no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_req | input | 1 | CPU I/O request, held until acknowledged |
| io_we | input | 1 | 1 = write, 0 = read |
| io_port | input | 14 | Dword I/O port number |
| io_be | input | 4 | Byte lanes |
| io_wdata | input | 32 | Write data |
| io_ack | output | 1 | One-cycle completion |
| io_rdata | output | 32 | Read data, valid with io_ack |
| cfg_req | output | 1 | External configuration request |
| cfg_we | output | 1 | Configuration write |
| cfg_type1 | output | 1 | 1 when the bus number is not 0 |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_func | output | 3 | Target function |
| cfg_dw | output | 6 | Target dword index |
| cfg_be | output | 4 | Byte lanes |
| cfg_wdata | output | 32 | Write data |
| cfg_ack | input | 1 | Target completion |
| cfg_rdata | input | 32 | Target read data |
| fwd_req | output | 1 | Forwarded I/O request |
| fwd_we | output | 1 | Forwarded direction |
| fwd_port | output | 14 | Forwarded dword port |
| fwd_be | output | 4 | Forwarded byte lanes |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_ack | input | 1 | Forwarded completion |
| fwd_rdata | input | 32 | Forwarded read data |

## Verification
The bench writes all ones to the address port and expects reserved bits to read zero. A design that stored them would return 0xFFFFFFFF instead of 0x80FFFFFC. Half-width writes to the address port must leave the descriptor alone and appear on the forwarding interface; a loose byte-lane decode would corrupt the descriptor. Single-lane writes to the command register catch designs that write whole dwords or ignore the writable mask. Targets at bus 0 with a non-zero function, or with the enable bit clear, must produce no external request; a design that routes them wrongly shows a nonzero request count. A silent target lets the bench measure the request length and the all-ones read data. An off-by-one timer, or a design that hangs, fails these checks.

// File: rtl/cfgp_pkg.sv
// Shared types for the configuration access port.
package cfgp_pkg;
    localparam int PORT_AW = 14;

    // Decoded target descriptor held by the address latch.
    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] func;
        logic [5:0] dw;
    } cfg_desc_t;

    // Where an accepted CPU access is routed.
    typedef enum logic [2:0] {
        RT_DESC,
        RT_HOST,
        RT_NODEV,
        RT_EXT,
        RT_FWD
    } cfgp_route_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXT,
        ST_FWD,
        ST_RESP
    } cfgp_state_e;
endpackage

// File: rtl/cfgp_addr_latch.sv
// Target descriptor register. Loads on a full write strobe.
// Assumes the caller only strobes on a 32-bit write.
// Reserved bits are never stored.
module cfgp_addr_latch
    import cfgp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output cfg_desc_t   desc,
    output logic [31:0] rd_value
);
    // Capture only the meaningful fields of the written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc <= '0;
        end else if (wr_en) begin
            desc <= '{en: wdata[31], bus: wdata[23:16], dev: wdata[15:11],
                      func: wdata[10:8], dw: wdata[7:2]};
        end
    end

    // Reassemble the readable image with zeros in reserved positions.
    always_comb begin
        rd_value = {desc.en, 7'b0, desc.bus, desc.dev, desc.func, desc.dw, 2'b00};
    end

    p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(desc));
endmodule

// File: rtl/cfgp_hdr_regs.sv
// Host bridge header register file.
// Read-only identity words, a lane-writable command field under a mask,
// and zero elsewhere. The read path is combinational.
module cfgp_hdr_regs #(
    parameter logic [15:0] VENDOR_ID = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID = 16'h3000,
    parameter logic [31:0] CLASS_REV = 32'h0600_0001,
    parameter logic [15:0] CMD_WMASK = 16'h0146,
    parameter int          DW_W      = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW_W-1:0] dw_idx,
    input  logic [3:0]      be,
    input  logic [31:0]     wdata,
    output logic [31:0]     rdata
);
    localparam int CMD_LANES = 2;
    localparam logic [DW_W-1:0] DW_ID  = DW_W'(0);
    localparam logic [DW_W-1:0] DW_CMD = DW_W'(1);
    localparam logic [DW_W-1:0] DW_CLS = DW_W'(2);

    logic [15:0] cmd_q;
    logic        cmd_sel;

    assign cmd_sel = wr_en && (dw_idx == DW_CMD);

    // One register slice per command byte lane.
    for (genvar g = 0; g < CMD_LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmd_q[8*g +: 8] <= 8'h00;
            else if (cmd_sel && be[g])
                cmd_q[8*g +: 8] <= wdata[8*g +: 8] & CMD_WMASK[8*g +: 8];
        end
    end

    // Select the addressed header dword.
    always_comb begin
        case (dw_idx)
            DW_ID:   rdata = {DEVICE_ID, VENDOR_ID};
            DW_CMD:  rdata = {16'h0000, cmd_q};
            DW_CLS:  rdata = CLASS_REV;
            default: rdata = 32'h0;
        endcase
    end

    p_cmd_other_dw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dw_idx != DW_CMD) |=> $stable(cmd_q));
endmodule

// File: rtl/cfg_access_port.sv
// Configuration access port. Accepts held CPU I/O requests and routes
// each one to the descriptor latch, the host header, an absent-function
// responder, the external configuration interface (with timeout) or the
// forwarding interface. Then it acknowledges for one cycle.
// Assumes the master keeps its request stable until io_ack.
module cfg_access_port
    import cfgp_pkg::*;
#(
    parameter logic [13:0] DESC_PORT   = 14'h33E,
    parameter logic [13:0] DATA_PORT   = 14'h33F,
    parameter int          TIMEOUT_CYC = 64,
    parameter logic [15:0] VENDOR_ID   = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID   = 16'h3000,
    parameter logic [31:0] CLASS_REV   = 32'h0600_0001,
    parameter logic [15:0] CMD_WMASK   = 16'h0146
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_req,
    input  logic        io_we,
    input  logic [13:0] io_port,
    input  logic [3:0]  io_be,
    input  logic [31:0] io_wdata,
    output logic        io_ack,
    output logic [31:0] io_rdata,
    output logic        cfg_req,
    output logic        cfg_we,
    output logic        cfg_type1,
    output logic [7:0]  cfg_bus,
    output logic [4:0]  cfg_dev,
    output logic [2:0]  cfg_func,
    output logic [5:0]  cfg_dw,
    output logic [3:0]  cfg_be,
    output logic [31:0] cfg_wdata,
    input  logic        cfg_ack,
    input  logic [31:0] cfg_rdata,
    output logic        fwd_req,
    output logic        fwd_we,
    output logic [13:0] fwd_port,
    output logic [3:0]  fwd_be,
    output logic [31:0] fwd_wdata,
    input  logic        fwd_ack,
    input  logic [31:0] fwd_rdata
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

    cfgp_state_e state;
    cfgp_route_e route;
    cfg_desc_t   desc;
    logic [31:0] desc_rd, hdr_rd, rdata_q, wdata_q;
    logic [13:0] port_q;
    logic [3:0]  be_q;
    logic        we_q, accept, desc_wr, hdr_wr;
    logic [TW-1:0] tmr;

    assign accept  = (state == ST_IDLE) && io_req;
    assign desc_wr = accept && io_we && (route == RT_DESC);
    assign hdr_wr  = accept && io_we && (route == RT_HOST);

    cfgp_addr_latch u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(desc_wr), .wdata(io_wdata),
        .desc(desc), .rd_value(desc_rd)
    );

    cfgp_hdr_regs #(
        .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
        .CLASS_REV(CLASS_REV), .CMD_WMASK(CMD_WMASK), .DW_W(6)
    ) u_hdr (
        .clk(clk), .rst_n(rst_n), .wr_en(hdr_wr), .dw_idx(desc.dw),
        .be(io_be), .wdata(io_wdata), .rdata(hdr_rd)
    );

    // Decide where the access on the CPU bus belongs.
    always_comb begin
        if (io_port == DESC_PORT && io_be == 4'hF)
            route = RT_DESC;
        else if (io_port == DATA_PORT && desc.en) begin
            if (desc.bus != 8'h00 || desc.dev != 5'h00)
                route = RT_EXT;
            else if (desc.func == 3'h0)
                route = RT_HOST;
            else
                route = RT_NODEV;
        end else
            route = RT_FWD;
    end

    // Sequence one access: accept, wait on a target, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rdata_q <= '0;
            wdata_q <= '0;
            port_q  <= '0;
            be_q    <= '0;
            we_q    <= 1'b0;
            tmr     <= '0;
        end else begin
            case (state)
                ST_IDLE: if (io_req) begin
                    we_q    <= io_we;
                    be_q    <= io_be;
                    wdata_q <= io_wdata;
                    port_q  <= io_port;
                    tmr     <= '0;
                    case (route)
                        RT_DESC:  begin rdata_q <= io_we ? '0 : desc_rd; state <= ST_RESP; end
                        RT_HOST:  begin rdata_q <= io_we ? '0 : hdr_rd;  state <= ST_RESP; end
                        RT_NODEV: begin rdata_q <= io_we ? '0 : '1;      state <= ST_RESP; end
                        RT_EXT:   state <= ST_EXT;
                        default:  state <= ST_FWD;
                    endcase
                end
                ST_EXT: begin
                    if (cfg_ack) begin
                        rdata_q <= we_q ? '0 : cfg_rdata;
                        state   <= ST_RESP;
                    end else if (tmr == T_LAST) begin
                        rdata_q <= we_q ? '0 : '1;
                        state   <= ST_RESP;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_FWD: if (fwd_ack) begin
                    rdata_q <= we_q ? '0 : fwd_rdata;
                    state   <= ST_RESP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the three interfaces from state and captured request.
    always_comb begin
        io_ack    = (state == ST_RESP);
        io_rdata  = rdata_q;
        cfg_req   = (state == ST_EXT);
        cfg_we    = we_q;
        cfg_type1 = (desc.bus != 8'h00);
        cfg_bus   = desc.bus;
        cfg_dev   = desc.dev;
        cfg_func  = desc.func;
        cfg_dw    = desc.dw;
        cfg_be    = be_q;
        cfg_wdata = wdata_q;
        fwd_req   = (state == ST_FWD);
        fwd_we    = we_q;
        fwd_port  = port_q;
        fwd_be    = be_q;
        fwd_wdata = wdata_q;
    end

    // Checker counter: consecutive cycles with cfg_req high.
    logic [TW:0] req_len;
    always_ff @(posedge clk) begin
        if (!rst_n)       req_len <= '0;
        else if (cfg_req) req_len <= req_len + 1'b1;
        else              req_len <= '0;
    end

    p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |=> !io_ack);
    p_no_cfg_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_req) |-> desc.en);
    p_host_internal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (cfg_bus != 8'h00 || cfg_dev != 5'h00));
    p_timeout_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_len <= (TW+1)'(TIMEOUT_CYC));
    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_req && fwd_req));
endmodule

// File: tb/cfg_access_port_tb.sv
module cfg_access_port_tb;
    localparam int TO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        io_req = 0, io_we = 0;
    logic [13:0] io_port = 0;
    logic [3:0]  io_be = 0;
    logic [31:0] io_wdata = 0;
    logic        io_ack;
    logic [31:0] io_rdata;
    logic        cfg_req, cfg_we, cfg_type1;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_func;
    logic [5:0]  cfg_dw;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 0;
    logic [31:0] cfg_rdata = 0;
    logic        fwd_req, fwd_we;
    logic [13:0] fwd_port;
    logic [3:0]  fwd_be;
    logic [31:0] fwd_wdata;
    logic        fwd_ack = 0;
    logic [31:0] fwd_rdata = 0;

    cfg_access_port #(.TIMEOUT_CYC(TO)) u_dut (.*);

    int n_chk = 0, n_bad = 0;

    // External target model.
    logic        ext_present = 1;
    int          ext_delay = 0, ext_wait = 0, ext_cnt = 0, cur_len = 0, last_len = 0;
    logic [31:0] ext_data = 0;
    logic        rq_prev = 0, rec_we = 0, rec_t1 = 0;
    logic [7:0]  rec_bus = 0;
    logic [4:0]  rec_dev = 0;
    logic [2:0]  rec_func = 0;
    logic [5:0]  rec_dw = 0;
    logic [3:0]  rec_be = 0;
    logic [31:0] rec_wd = 0;
    always @(negedge clk) begin
        if (cfg_req && !rq_prev) begin
            ext_cnt++;
            rec_we = cfg_we; rec_t1 = cfg_type1; rec_bus = cfg_bus; rec_dev = cfg_dev;
            rec_func = cfg_func; rec_dw = cfg_dw; rec_be = cfg_be; rec_wd = cfg_wdata;
        end
        if (cfg_req) cur_len++;
        else if (rq_prev) begin last_len = cur_len; cur_len = 0; end
        rq_prev = cfg_req;
        if (cfg_req && !cfg_ack) begin
            if (ext_present && ext_wait == ext_delay) begin
                cfg_ack = 1; cfg_rdata = ext_data;
            end else ext_wait++;
        end else begin
            cfg_ack = 0; ext_wait = 0;
        end
    end

    // Forwarding target model: echoes a port-derived value.
    int          fwd_cnt = 0;
    logic        f_prev = 0, frec_we = 0;
    logic [13:0] frec_port = 0;
    logic [3:0]  frec_be = 0;
    logic [31:0] frec_wd = 0;
    always @(negedge clk) begin
        if (fwd_req && !f_prev) begin
            fwd_cnt++; frec_we = fwd_we; frec_port = fwd_port; frec_be = fwd_be; frec_wd = fwd_wdata;
        end
        f_prev = fwd_req;
        if (fwd_req && !fwd_ack) begin
            fwd_ack = 1; fwd_rdata = 32'h5A00_0000 | {18'h0, fwd_port};
        end else fwd_ack = 0;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [13:0] port, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        io_req = 1; io_we = we; io_port = port; io_be = be; io_wdata = wd;
        @(negedge clk);
        while (!io_ack) @(negedge clk);
        rd = io_rdata;
        io_req = 0;
        @(negedge clk);
        check("R1 ack one cycle", {31'b0, io_ack}, 32'h0);
    endtask

    localparam logic [13:0] AP = 14'h33E, DP = 14'h33F;
    logic [31:0] r;

    task automatic t_reset;
        check("R11 cfg_req idle", {31'b0, cfg_req}, 0);
        check("R11 fwd_req idle", {31'b0, fwd_req}, 0);
        xfer(0, AP, 4'hF, 0, r);
        check("R11 descriptor reset", r, 0);
    endtask

    task automatic t_desc;
        int f0;
        f0 = fwd_cnt;
        xfer(1, AP, 4'h3, 32'h8000_0004, r);
        check("R2 narrow write forwarded", fwd_cnt - f0, 1);
        xfer(0, AP, 4'hF, 0, r);
        check("R2 latch unchanged", r, 0);
        xfer(0, AP, 4'h1, 0, r);
        check("R2 narrow read forwarded", r, 32'h5A00_033E);
        xfer(1, AP, 4'hF, 32'hFFFF_FFFF, r);
        xfer(0, AP, 4'hF, 0, r);
        check("R3 reserved bits zero", r, 32'h80FF_FFFC);
    endtask

    task automatic t_host;
        int e0;
        e0 = ext_cnt;
        xfer(1, AP, 4'hF, 32'h8000_0004, r);
        xfer(1, DP, 4'hF, 32'hFFFF_FFFF, r);
        xfer(0, DP, 4'hF, 0, r);
        check("R1 R6 command masked", r, 32'h0000_0146);
        xfer(1, DP, 4'hF, 0, r);
        xfer(1, DP, 4'h2, 32'h0000_FF00, r);
        xfer(0, DP, 4'hF, 0, r);
        check("R5 single lane write", r, 32'h0000_0100);
        xfer(1, DP, 4'h1, 32'h0000_00FF, r);
        xfer(0, DP, 4'hF, 0, r);
        check("R5 second lane write", r, 32'h0000_0146);
        xfer(1, AP, 4'hF, 32'h8000_0000, r);
        xfer(0, DP, 4'hF, 0, r);
        check("R6 id dword", r, 32'h3000_1A2B);
        xfer(1, AP, 4'hF, 32'h8000_0008, r);
        xfer(0, DP, 4'hF, 0, r);
        check("R6 class dword", r, 32'h0600_0001);
        xfer(1, AP, 4'hF, 32'h8000_0014, r);
        xfer(1, DP, 4'hF, 32'hFFFF_FFFF, r);
        xfer(0, DP, 4'hF, 0, r);
        check("R6 unused dword", r, 0);
        check("R6 no external", ext_cnt - e0, 0);
    endtask

    task automatic t_nodev;
        int e0;
        e0 = ext_cnt;
        xfer(1, AP, 4'hF, 32'h8000_0104, r);
        xfer(1, DP, 4'hF, 32'h0, r);
        xfer(0, DP, 4'hF, 0, r);
        check("R7 absent func reads ones", r, 32'hFFFF_FFFF);
        check("R7 no external", ext_cnt - e0, 0);
        xfer(1, AP, 4'hF, 32'h8000_0004, r);
        xfer(0, DP, 4'hF, 0, r);
        check("R7 write had no effect", r, 32'h0000_0146);
    endtask

    task automatic t_ext;
        ext_present = 1; ext_delay = 3; ext_data = 32'hDEAD_BEEF;
        xfer(1, AP, 4'hF, 32'h8000_1808, r);
        xfer(0, DP, 4'hF, 0, r);
        check("R8 read data", r, 32'hDEAD_BEEF);
        check("R8 type0", {31'b0, rec_t1}, 0);
        check("R8 fields bus0", {rec_bus, 3'b0, rec_dev, 5'b0, rec_func, 2'b0, rec_dw}, {8'h00, 3'b0, 5'd3, 5'b0, 3'd0, 2'b0, 6'd2});
        ext_delay = 0;
        xfer(1, AP, 4'hF, 32'h8012_2A0C, r);
        xfer(1, DP, 4'h4, 32'h00AB_0000, r);
        check("R8 type1", {31'b0, rec_t1}, 1);
        check("R8 fields bus18", {rec_bus, 3'b0, rec_dev, 5'b0, rec_func, 2'b0, rec_dw}, {8'h12, 3'b0, 5'd5, 5'b0, 3'd2, 2'b0, 6'd3});
        check("R5 external lanes", {28'b0, rec_be}, 32'h4);
        check("R8 write data", rec_wd, 32'h00AB_0000);
        check("R8 write dir", {31'b0, rec_we}, 1);
    endtask

    task automatic t_timeout;
        ext_present = 0;
        xfer(1, AP, 4'hF, 32'h8003_0000, r);
        xfer(0, DP, 4'hF, 0, r);
        check("R9 timeout read ones", r, 32'hFFFF_FFFF);
        check("R9 request length", last_len, TO);
        xfer(1, DP, 4'hF, 32'h1234_5678, r);
        check("R9 write request length", last_len, TO);
        ext_present = 1;
    endtask

    task automatic t_fwd;
        int e0, f0;
        e0 = ext_cnt; f0 = fwd_cnt;
        xfer(1, AP, 4'hF, 32'h0000_1804, r);
        xfer(0, DP, 4'hC, 0, r);
        check("R4 disabled forwarded", r, 32'h5A00_033F);
        check("R4 no cfg request", ext_cnt - e0, 0);
        xfer(1, 14'h0018, 4'h6, 32'h00C3_3C00, r);
        check("R10 fwd port", {18'b0, frec_port}, 32'h18);
        check("R10 fwd lanes/dir", {27'b0, frec_we, frec_be}, {27'b0, 1'b1, 4'h6});
        check("R10 fwd data", frec_wd, 32'h00C3_3C00);
        xfer(0, 14'h0020, 4'hF, 0, r);
        check("R10 fwd read data", r, 32'h5A00_0020);
        check("R10 fwd count", fwd_cnt - f0, 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_desc;
        t_host;
        t_nodev;
        t_ext;
        t_timeout;
        t_fwd;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule